// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block picks the two source operand values that a five-stage integer pipeline writes into its decode/execute register. Each source of the instruction in decode is compared against the destinations of the instructions in execute, memory and writeback. The operand is then taken from the youngest matching producer, or from the register file when nothing matches. The selection happens at the input of the decode/execute register. A forwarded value is therefore already latched when the consumer enters execute, and no multiplexer is needed in front of the ALU.

The execute-stage value used for bypassing is the combinational result that feeds the execute/memory register. The memory-stage value is the one that feeds the memory/writeback register. A load has no data until the end of its memory cycle, so a load sitting in execute is never a bypass source. If that load writes a register the decoding instruction actually reads, the block raises a stall for one cycle and the decode/execute register receives a bubble. On the next cycle the load has moved to memory, and its data is bypassed from there. This covers both sources of a register-register operation, the compared registers of a branch, and the base and store data of a store.

Top module: `dec_fwd_unit`

## Requirements
- R1: While reset is high, both registered operands read 0 and the bubble flag reads 1.
- R2: A source register number of 0 always captures the value 0, whatever any producer writes.
- R3: A non-load producer in execute with write enable set and a destination equal to a nonzero source supplies `ex_result` to that operand at the next clock edge, with no stall.
- R4: When execute does not supply a source, a memory-stage producer with write enable set and a matching destination supplies `mem_result`.
- R5: When execute and memory both match a source, the execute value is captured.
- R6: A load in execute (write enable and load flag set) whose destination equals a used nonzero source raises `stall` combinationally in that cycle. At the next edge both operands capture 0 and the bubble flag becomes 1.
- R7: In the cycle after such a stall, with the load moved to memory, the load data on `mem_result` is captured for the dependent source and `stall` is low.
- R8: A producer whose write enable is clear never supplies an operand and never causes a stall.
- R9: A source whose use flag is clear never causes a stall.
- R10: When neither execute nor memory supplies a source, a writeback write to the same register in the same cycle supplies `wb_data`, bypassing the register file read.
- R11: With no matching producer, the register file read data is captured, and a cycle without stall clears the bubble flag.
- R12: The two sources are selected independently, so each may take its value from a different stage in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src_a | input | RAW | First source register number of the decoding instruction |
| id_src_b | input | RAW | Second source register number of the decoding instruction |
| id_use_a | input | 1 | First source is actually read |
| id_use_b | input | 1 | Second source is actually read |
| rf_data_a | input | XLEN | Register file read data for the first source |
| rf_data_b | input | XLEN | Register file read data for the second source |
| ex_dst | input | RAW | Destination of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| ex_result | input | XLEN | Value the execute stage is producing now |
| mem_dst | input | RAW | Destination of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| mem_result | input | XLEN | Value the memory stage is producing now |
| wb_dst | input | RAW | Register being written back this cycle |
| wb_wen | input | 1 | Writeback write enable |
| wb_data | input | XLEN | Writeback data |
| stall | output | 1 | Hold fetch and decode for this cycle |
| idex_op_a | output | XLEN | Registered first operand of the decode/execute register |
| idex_op_b | output | XLEN | Registered second operand of the decode/execute register |
| idex_bubble | output | 1 | Decode/execute register holds a bubble |

## Verification
The assertions assume that all inputs are two-state and settled before each rising edge. They also assume that `ex_result` and `mem_result` are the values at the stage outputs in the same cycle as the matching destination and enables. The bench drives every input on the falling edge with two-state values. It draws register numbers from a small range so that matches, double matches and register 0 come up often. The load-then-dependent sequence needs a correct pipeline shift: the load appears in memory one cycle after it stalled in execute. The bench builds that shift explicitly in directed steps, on top of the free random traffic.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [2:0] {
    SRC_ZERO = 3'd0,
    SRC_EX   = 3'd1,
    SRC_MEM  = 3'd2,
    SRC_WB   = 3'd3,
    SRC_RF   = 3'd4
  } fwd_src_e;
endpackage

// File: rtl/fwd_src_select.sv
module fwd_src_select
  import fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  src,
  input  logic [XLEN-1:0] rf_data,
  input  logic [RAW-1:0]  ex_dst,
  input  logic            ex_wen,
  input  logic            ex_load,
  input  logic [XLEN-1:0] ex_result,
  input  logic [RAW-1:0]  mem_dst,
  input  logic            mem_wen,
  input  logic [XLEN-1:0] mem_result,
  input  logic [RAW-1:0]  wb_dst,
  input  logic            wb_wen,
  input  logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] value,
  output logic            load_hit
);
  logic     src_nz;
  logic     ex_match, mem_match, wb_match;
  fwd_src_e pick;

  assign src_nz    = (src != '0);
  assign ex_match  = src_nz && ex_wen  && (ex_dst  == src);
  assign mem_match = src_nz && mem_wen && (mem_dst == src);
  assign wb_match  = src_nz && wb_wen  && (wb_dst  == src);
  assign load_hit  = ex_match && ex_load;

  // Youngest producer first; a load in execute has no data yet.
  always_comb begin
    if (!src_nz)                   pick = SRC_ZERO;
    else if (ex_match && !ex_load) pick = SRC_EX;
    else if (mem_match)            pick = SRC_MEM;
    else if (wb_match)             pick = SRC_WB;
    else                           pick = SRC_RF;
  end

  always_comb begin
    unique case (pick)
      SRC_ZERO: value = '0;
      SRC_EX:   value = ex_result;
      SRC_MEM:  value = mem_result;
      SRC_WB:   value = wb_data;
      default:  value = rf_data;
    endcase
  end

  // R2: register 0 yields zero whatever the producers carry
  assert_zero_source_R2: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |-> (value == '0 && !load_hit));

  // R8: a producer that does not write never drives the operand
  assert_no_wen_no_ex_R8: assert property (@(posedge clk) disable iff (rst)
    (!ex_wen && !mem_wen && !wb_wen) |-> (value == (src == '0 ? '0 : rf_data)));
endmodule

// File: rtl/fwd_load_hazard.sv
module fwd_load_hazard #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] load_hit,
  input  logic [NSRC-1:0] src_used,
  input  logic            ex_load,
  output logic            stall
);
  logic [NSRC-1:0] need;

  for (genvar i = 0; i < NSRC; i++) begin : g_need
    assign need[i] = load_hit[i] && src_used[i];
  end

  assign stall = |need;

  // R6: a stall is only ever caused by a load in execute
  assert_stall_needs_load_R6: assert property (@(posedge clk) disable iff (rst)
    stall |-> ex_load);

  // R9: sources that are not read cannot stall
  assert_unused_no_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (src_used == '0) |-> !stall);
endmodule

// File: rtl/fwd_operand_reg.sv
module fwd_operand_reg #(
  parameter int XLEN = 32,
  parameter int NSRC = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bubble_in,
  input  logic [NSRC-1:0][XLEN-1:0] d,
  output logic [NSRC-1:0][XLEN-1:0] q,
  output logic                      bubble_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      bubble_q <= 1'b1;
    end else if (bubble_in) begin
      q        <= '0;
      bubble_q <= 1'b1;
    end else begin
      q        <= d;
      bubble_q <= 1'b0;
    end
  end

  // R6: a stall cycle leaves an empty slot in the decode/execute register
  assert_bubble_after_stall_R6: assert property (@(posedge clk) disable iff (rst)
    bubble_in |=> (bubble_q && q == '0));

  // R11: a cycle without stall loads a real instruction
  assert_no_bubble_when_free_R11: assert property (@(posedge clk) disable iff (rst)
    !bubble_in |=> !bubble_q);
endmodule

// File: rtl/dec_fwd_unit.sv
module dec_fwd_unit #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  id_src_a,
  input  logic [RAW-1:0]  id_src_b,
  input  logic            id_use_a,
  input  logic            id_use_b,
  input  logic [XLEN-1:0] rf_data_a,
  input  logic [XLEN-1:0] rf_data_b,
  input  logic [RAW-1:0]  ex_dst,
  input  logic            ex_wen,
  input  logic            ex_load,
  input  logic [XLEN-1:0] ex_result,
  input  logic [RAW-1:0]  mem_dst,
  input  logic            mem_wen,
  input  logic [XLEN-1:0] mem_result,
  input  logic [RAW-1:0]  wb_dst,
  input  logic            wb_wen,
  input  logic [XLEN-1:0] wb_data,
  output logic            stall,
  output logic [XLEN-1:0] idex_op_a,
  output logic [XLEN-1:0] idex_op_b,
  output logic            idex_bubble
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][RAW-1:0]  src_num;
  logic [NSRC-1:0][XLEN-1:0] rf_rd;
  logic [NSRC-1:0][XLEN-1:0] sel_val;
  logic [NSRC-1:0][XLEN-1:0] op_q;
  logic [NSRC-1:0]           src_used;
  logic [NSRC-1:0]           load_hit;

  assign src_num  = {id_src_b, id_src_a};
  assign rf_rd    = {rf_data_b, rf_data_a};
  assign src_used = {id_use_b, id_use_a};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    fwd_src_select #(.XLEN(XLEN), .RAW(RAW)) u_sel (
      .clk        (clk),
      .rst        (rst),
      .src        (src_num[i]),
      .rf_data    (rf_rd[i]),
      .ex_dst     (ex_dst),
      .ex_wen     (ex_wen),
      .ex_load    (ex_load),
      .ex_result  (ex_result),
      .mem_dst    (mem_dst),
      .mem_wen    (mem_wen),
      .mem_result (mem_result),
      .wb_dst     (wb_dst),
      .wb_wen     (wb_wen),
      .wb_data    (wb_data),
      .value      (sel_val[i]),
      .load_hit   (load_hit[i])
    );
  end

  fwd_load_hazard #(.NSRC(NSRC)) u_haz (
    .clk      (clk),
    .rst      (rst),
    .load_hit (load_hit),
    .src_used (src_used),
    .ex_load  (ex_load),
    .stall    (stall)
  );

  fwd_operand_reg #(.XLEN(XLEN), .NSRC(NSRC)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .bubble_in (stall),
    .d         (sel_val),
    .q         (op_q),
    .bubble_q  (idex_bubble)
  );

  assign idex_op_a = op_q[0];
  assign idex_op_b = op_q[1];

  // R3: a non-load result in execute reaches the consumer with no stall
  assert_ex_bypass_a_R3: assert property (@(posedge clk) disable iff (rst)
    (ex_wen && !ex_load && ex_dst == id_src_a && id_src_a != '0)
    |=> (idex_op_a == $past(ex_result) || $past(stall)));

  // R3: no stall is ever requested for a non-load producer
  assert_alu_no_stall_R3: assert property (@(posedge clk) disable iff (rst)
    !ex_load |-> !stall);

  // R5: execute beats memory for the second source
  assert_ex_over_mem_b_R5: assert property (@(posedge clk) disable iff (rst)
    (!stall && ex_wen && !ex_load && mem_wen && ex_dst == id_src_b
     && mem_dst == id_src_b && id_src_b != '0)
    |=> (idex_op_b == $past(ex_result)));

  // R1: the register leaves reset empty
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (idex_bubble && idex_op_a == '0 && idex_op_b == '0));
endmodule

// File: tb/dec_fwd_unit_tb_top.sv
module dec_fwd_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [RAW-1:0]  id_src_a = '0, id_src_b = '0, ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic            id_use_a = 1'b0, id_use_b = 1'b0;
  logic            ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
  logic [XLEN-1:0] rf_data_a = '0, rf_data_b = '0, ex_result = '0, mem_result = '0, wb_data = '0;
  logic            stall, idex_bubble;
  logic [XLEN-1:0] idex_op_a, idex_op_b;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_fwd_unit #(.XLEN(XLEN), .NREG(NREG)) dut_i (
    .clk(clk), .rst(rst),
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .id_use_a(id_use_a), .id_use_b(id_use_b),
    .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load), .ex_result(ex_result),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_result(mem_result),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_data(wb_data),
    .stall(stall), .idex_op_a(idex_op_a), .idex_op_b(idex_op_b),
    .idex_bubble(idex_bubble)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: walk the producers from youngest to oldest.
  function automatic logic [XLEN-1:0] ref_value(int src, logic [XLEN-1:0] rf, output string tag);
    if (src == 0) begin tag = "R2"; return '0; end
    if (ex_wen && !ex_load && int'(ex_dst) == src) begin
      tag = (mem_wen && int'(mem_dst) == src) ? "R5" : "R3";
      return ex_result;
    end
    if (mem_wen && int'(mem_dst) == src) begin tag = "R4"; return mem_result; end
    if (wb_wen && int'(wb_dst) == src) begin tag = "R10"; return wb_data; end
    tag = "R11";
    return rf;
  endfunction

  function automatic bit ref_stall();
    bit hit_a, hit_b;
    hit_a = id_use_a && id_src_a != 0 && ex_wen && ex_load && ex_dst == id_src_a;
    hit_b = id_use_b && id_src_b != 0 && ex_wen && ex_load && ex_dst == id_src_b;
    return hit_a || hit_b;
  endfunction

  // Inputs are set at a falling edge; check stall, then the register one edge later.
  task automatic run_cycle(input string note);
    string tag_a, tag_b;
    logic [XLEN-1:0] exp_a, exp_b;
    bit exp_stall;
    #1;
    exp_stall = ref_stall();
    exp_a = ref_value(int'(id_src_a), rf_data_a, tag_a);
    exp_b = ref_value(int'(id_src_b), rf_data_b, tag_b);
    check({exp_stall ? "R6" : "R9", " stall ", note}, XLEN'(stall), XLEN'(exp_stall));
    if (exp_stall) begin
      exp_a = '0; exp_b = '0; tag_a = "R6"; tag_b = "R6";
    end
    @(negedge clk);
    check({tag_a, " op_a ", note}, idex_op_a, exp_a);
    check({tag_b, " op_b ", note}, idex_op_b, exp_b);
    check({exp_stall ? "R6" : "R11", " bubble ", note}, XLEN'(idex_bubble), XLEN'(exp_stall));
  endtask

  task automatic quiet();
    ex_wen = 0; ex_load = 0; mem_wen = 0; wb_wen = 0;
    id_use_a = 1; id_use_b = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 op_a reset", idex_op_a, '0);
    check("R1 op_b reset", idex_op_b, '0);
    check("R1 bubble reset", XLEN'(idex_bubble), XLEN'(1));
    rst = 1'b0;

    // R3 plain execute bypass
    quiet(); id_src_a = 3; id_src_b = 4; rf_data_a = 32'h11; rf_data_b = 32'h22;
    ex_wen = 1; ex_dst = 3; ex_result = 32'hA0A0;
    run_cycle("R3 ex");
    // R8 write enable clear on every producer
    quiet(); ex_dst = 3; mem_dst = 3; wb_dst = 3; ex_result = 32'hDEAD;
    run_cycle("R8 no wen");
    ex_load = 1; run_cycle("R8 load without wen");
    // R12 store: base from execute, data from memory
    quiet(); id_src_a = 6; id_src_b = 7; ex_wen = 1; ex_dst = 6; ex_result = 32'h600D;
    mem_wen = 1; mem_dst = 7; mem_result = 32'h7777;
    run_cycle("R12 split");
    // R9 load hits a source that is not read
    quiet(); id_use_b = 0; id_src_a = 1; id_src_b = 9; ex_wen = 1; ex_load = 1; ex_dst = 9;
    run_cycle("R9 unused");
    // R6 then R7: load stalls, then moves to memory
    quiet(); id_src_a = 5; id_src_b = 2; ex_wen = 1; ex_load = 1; ex_dst = 5;
    ex_result = 32'hBAD0;
    run_cycle("R6 load use");
    quiet(); mem_wen = 1; mem_dst = 5; mem_result = 32'h10AD;
    run_cycle("R7 after stall");
    // R10 writeback bypass
    quiet(); id_src_a = 8; id_src_b = 0; wb_wen = 1; wb_dst = 8; wb_data = 32'hB00B;
    rf_data_b = 32'hFFFF;
    run_cycle("R10 wb");

    for (int n = 0; n < 3000; n++) begin
      id_src_a = RAW'($urandom_range(0, 7));
      id_src_b = RAW'($urandom_range(0, 7));
      id_use_a = ($urandom_range(0, 7) != 0);
      id_use_b = ($urandom_range(0, 7) != 0);
      rf_data_a = $urandom; rf_data_b = $urandom;
      ex_dst = RAW'($urandom_range(0, 7)); ex_wen = $urandom_range(0, 1);
      ex_load = ($urandom_range(0, 3) == 0); ex_result = $urandom;
      mem_dst = RAW'($urandom_range(0, 7)); mem_wen = $urandom_range(0, 1);
      mem_result = $urandom;
      wb_dst = RAW'($urandom_range(0, 7)); wb_wen = $urandom_range(0, 1);
      wb_data = $urandom;
      run_cycle("random");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule